// File: doc/BRIEF.md
# Vertical Sync Window Controller

This block keeps a video line counter and decides, line by line, whether an incoming vertical sync pulse should restart that counter. It serves both the 625-line (50 Hz) and the 525-line (60 Hz) standards.

While the norm status input reports a stable norm, a pulse restarts the counter only inside a narrow window around the expected field length. While the norm is lost, any pulse restarts it. With no usable pulse, the counter restarts at a timeout line. That line depends on the window in use, on the loop-locked flag and on the forced-mode control.

Each restart emits a one-cycle field-start strobe. In free mode, the block infers the standard from the line count at which an accepted pulse arrived. In forced mode, the standard is pinned to a control input.

Top module: `vsync_window_ctrl`

## Requirements
- R1: After a synchronous reset, `line_cnt` is 1, `field_start` is 0 and `is_60` is 0 (50 Hz).
- R2: A cycle with `line_stb` high and no restart raises `line_cnt` by exactly 1 at the next edge. A cycle with neither leaves the count unchanged.
- R3: With `norm_ok` high on the 50 Hz side, `win_open` is high exactly when 622 < `line_cnt` < 628. A `vsync` pulse outside that range is ignored, so the count is kept and no field start occurs.
- R4: With `norm_ok` high, the edge after `line_cnt` reaches 628 (50 Hz) or 528 (60 Hz) sets the count to 1, whether or not a strobe is present.
- R5: With `norm_ok` low, `win_open` is high and a `vsync` pulse at any count restarts the counter at the next edge.
- R6: With `norm_ok` low and no pulse, the timeout line is 722 when both `loop_lock` and `force_en` are high. Otherwise it is 628, on either side.
- R7: With `norm_ok` high on the 60 Hz side, the accept window is 522 < `line_cnt` < 528. Pulses outside it are ignored.
- R8: With `force_en` low, an accepted pulse sets `is_60` at the next edge to 1 if `line_cnt` was below 576, and to 0 otherwise.
- R9: With `force_en` high, `is_60` takes the value of `force_60` at the next edge, and accepted pulses do not change it.
- R10: `field_start` is high for exactly the cycle in which `line_cnt` has just been set to 1 by a restart of either cause, and is low otherwise.
- R11: When an accepted pulse and `line_stb` arrive in the same cycle, the restart wins: the count becomes 1, not the incremented value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb | input | 1 | One-cycle strobe per video line |
| vsync | input | 1 | Vertical sync pulse, one cycle |
| norm_ok | input | 1 | 1 = stable norm (narrow window), 0 = wide search |
| loop_lock | input | 1 | Line loop locked |
| force_en | input | 1 | Forced-standard mode |
| force_60 | input | 1 | Standard chosen in forced mode (1 = 60 Hz) |
| line_cnt | output | LC_W (10) | Current line count, starts at 1 |
| field_start | output | 1 | One-cycle pulse on every counter restart |
| win_open | output | 1 | Accept window currently open |
| is_60 | output | 1 | Detected or forced standard (1 = 60 Hz) |

## Verification
Every registered result is due one edge after the cycle that causes it:
- `line_cnt`, `field_start` and `is_60` change at the edge following the strobe, pulse or timeout line.
- `win_open` follows the current count and mode inputs in the same cycle.

The bench drives inputs on the falling edge. Its behavioural model advances on the rising edge, and the comparison runs 2 ns later, so every clock is checked after the outputs settle and before inputs move. Directed checks read the ports right after the edge that settles each case, such as the edge after count 628 or the edge after an ignored pulse.

// File: rtl/vswc_pkg.sv
package vswc_pkg;
  // Lower edge of the narrow accept window (exclusive).
  function automatic int win_low(input int frame_lines);
    return frame_lines - 3;
  endfunction

  // Upper edge of the narrow accept window (exclusive); also the narrow timeout.
  function automatic int win_high(input int frame_lines);
    return frame_lines + 3;
  endfunction

  // Line at which the counter restarts when no pulse is accepted.
  function automatic int timeout_line(input bit narrow, input bit side_60,
                                      input bit lock_forced, input int f50,
                                      input int f60, input int wide_locked);
    if (narrow) return side_60 ? win_high(f60) : win_high(f50);
    return lock_forced ? wide_locked : win_high(f50);
  endfunction

  // Standard inferred from the count at which a pulse was accepted.
  function automatic bit count_means_60(input int lc, input int split_line);
    return lc < split_line;
  endfunction
endpackage

// File: rtl/vswc_line_counter.sv
module vswc_line_counter #(
  parameter int LC_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_stb,
  input  logic            restart,
  output logic [LC_W-1:0] line_cnt,
  output logic            field_start
);
  localparam logic [LC_W-1:0] FIRST = LC_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt    <= FIRST;
      field_start <= 1'b0;
    end else begin
      field_start <= restart;
      if (restart)       line_cnt <= FIRST;
      else if (line_stb) line_cnt <= line_cnt + FIRST;
    end
  end
endmodule

// File: rtl/vswc_window.sv
module vswc_window
  import vswc_pkg::*;
#(
  parameter int LC_W        = 10,
  parameter int F50_LINES   = 625,
  parameter int F60_LINES   = 525,
  parameter int WIDE_LOCKED = 722
) (
  input  logic [LC_W-1:0] line_cnt,
  input  logic            narrow,
  input  logic            side_60,
  input  logic            lock_forced,
  input  logic            vsync,
  output logic            in_window,
  output logic            accept,
  output logic            timeout_hit,
  output logic            restart
);
  int lc_i, frame, tmo;

  always_comb begin
    lc_i        = int'(line_cnt);
    frame       = side_60 ? F60_LINES : F50_LINES;
    tmo         = timeout_line(narrow, side_60, lock_forced,
                               F50_LINES, F60_LINES, WIDE_LOCKED);
    in_window   = narrow ? ((lc_i > win_low(frame)) && (lc_i < win_high(frame)))
                         : 1'b1;
    accept      = vsync && in_window;
    timeout_hit = lc_i >= tmo;
    restart     = accept || timeout_hit;
  end
endmodule

// File: rtl/vswc_side_sel.sv
module vswc_side_sel
  import vswc_pkg::*;
#(
  parameter int LC_W       = 10,
  parameter int SPLIT_LINE = 576
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            force_en,
  input  logic            force_60,
  input  logic            accept,
  input  logic [LC_W-1:0] line_cnt,
  output logic            is_60
);
  always_ff @(posedge clk) begin
    if (!rst_n)        is_60 <= 1'b0;
    else if (force_en) is_60 <= force_60;
    else if (accept)   is_60 <= count_means_60(int'(line_cnt), SPLIT_LINE);
  end
endmodule

// File: rtl/vsync_window_ctrl.sv
module vsync_window_ctrl #(
  parameter int LC_W        = 10,
  parameter int F50_LINES   = 625,
  parameter int F60_LINES   = 525,
  parameter int WIDE_LOCKED = 722,
  parameter int SPLIT_LINE  = 576
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_stb,
  input  logic            vsync,
  input  logic            norm_ok,
  input  logic            loop_lock,
  input  logic            force_en,
  input  logic            force_60,
  output logic [LC_W-1:0] line_cnt,
  output logic            field_start,
  output logic            win_open,
  output logic            is_60
);
  logic accept;
  logic timeout_hit;
  logic restart;
  logic lock_forced;

  assign lock_forced = loop_lock && force_en;

  vswc_window #(
    .LC_W(LC_W), .F50_LINES(F50_LINES), .F60_LINES(F60_LINES),
    .WIDE_LOCKED(WIDE_LOCKED)
  ) u_window (
    .line_cnt(line_cnt), .narrow(norm_ok), .side_60(is_60),
    .lock_forced(lock_forced), .vsync(vsync), .in_window(win_open),
    .accept(accept), .timeout_hit(timeout_hit), .restart(restart)
  );

  vswc_line_counter #(.LC_W(LC_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .restart(restart),
    .line_cnt(line_cnt), .field_start(field_start)
  );

  vswc_side_sel #(.LC_W(LC_W), .SPLIT_LINE(SPLIT_LINE)) u_side (
    .clk(clk), .rst_n(rst_n), .force_en(force_en), .force_60(force_60),
    .accept(accept), .line_cnt(line_cnt), .is_60(is_60)
  );
endmodule

// File: rtl/vswc_checker.sv
module vswc_checker #(
  parameter int LC_W        = 10,
  parameter int WIDE_LOCKED = 722
) (
  input logic            clk,
  input logic            rst_n,
  input logic            line_stb,
  input logic            vsync,
  input logic            norm_ok,
  input logic            force_en,
  input logic            force_60,
  input logic [LC_W-1:0] line_cnt,
  input logic            field_start,
  input logic            win_open,
  input logic            is_60,
  input logic            timeout_hit
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_start_is_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |-> line_cnt == LC_W'(1));

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(line_stb) && !field_start) |-> line_cnt == $past(line_cnt) + LC_W'(1));

  assert_outside_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_ok && vsync && !win_open && !timeout_hit) |=> !field_start);

  assert_timeout_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> field_start);

  assert_wide_accepts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!norm_ok && vsync) |=> field_start);

  assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt <= LC_W'(WIDE_LOCKED));

  assert_forced_side_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_en |=> is_60 == $past(force_60));
endmodule

bind vsync_window_ctrl vswc_checker #(.LC_W(LC_W), .WIDE_LOCKED(WIDE_LOCKED)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vsync(vsync),
  .norm_ok(norm_ok), .force_en(force_en), .force_60(force_60),
  .line_cnt(line_cnt), .field_start(field_start), .win_open(win_open),
  .is_60(is_60), .timeout_hit(timeout_hit)
);

// File: tb/vsync_window_ctrl_bench.sv
`timescale 1ns/1ps
module vsync_window_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_stb = 1'b0, vsync = 1'b0, norm_ok = 1'b1;
  logic       loop_lock = 1'b0, force_en = 1'b0, force_60 = 1'b0;
  logic [9:0] line_cnt;
  logic       field_start, win_open, is_60;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  vsync_window_ctrl u_vsync_window_ctrl (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vsync(vsync),
    .norm_ok(norm_ok), .loop_lock(loop_lock), .force_en(force_en),
    .force_60(force_60), .line_cnt(line_cnt), .field_start(field_start),
    .win_open(win_open), .is_60(is_60)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, written from the requirements.
  int m_lc = 1, m_fs = 0, m_60 = 0;

  function automatic int model_window(int lc, int side60, int narrow);
    int centre;
    if (narrow == 0) return 1;
    centre = side60 ? 525 : 625;
    return (lc > centre - 3 && lc < centre + 3) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int limit, take;
    if (!rst_n) begin
      m_lc = 1; m_fs = 0; m_60 = 0;
    end else begin
      if (norm_ok) limit = m_60 ? 528 : 628;
      else         limit = (loop_lock && force_en) ? 722 : 628;
      take = (vsync && model_window(m_lc, m_60, norm_ok)) ? 1 : 0;
      if (force_en)  m_60 = force_60;
      else if (take) m_60 = (m_lc < 576) ? 1 : 0;
      if (take || m_lc >= limit) begin m_lc = 1; m_fs = 1; end
      else begin m_fs = 0; if (line_stb) m_lc = m_lc + 1; end
    end
    #2;
    if (model_on) begin
      check("R2 model line_cnt", int'(line_cnt), m_lc);
      check("R10 model field_start", int'(field_start), m_fs);
      check("R8 model is_60", int'(is_60), m_60);
      check("R3 model win_open", int'(win_open), model_window(m_lc, m_60, norm_ok));
    end
  end

  task automatic tick(input bit stb, input bit vs);
    line_stb = stb; vsync = vs;
    @(negedge clk);
    line_stb = 1'b0; vsync = 1'b0;
  endtask

  task automatic go_to(input int target);
    for (int n = 0; n < 2000 && int'(line_cnt) != target; n++) tick(1'b1, 1'b0);
  endtask

  task automatic run_to_restart(output int peak);
    peak = int'(line_cnt);
    for (int n = 0; n < 2000; n++) begin
      tick(1'b1, 1'b0);
      if (field_start) break;
      peak = int'(line_cnt);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int peak;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset line_cnt", int'(line_cnt), 1);
    check("R1 reset field_start", int'(field_start), 0);
    check("R1 reset is_60", int'(is_60), 0);
    model_on = 1'b1;

    // Narrow window, 50 Hz: pulse far outside is ignored
    go_to(300);
    tick(1'b0, 1'b1);
    check("R3 ignored pulse keeps count", int'(line_cnt), 300);
    check("R3 ignored pulse no field start", int'(field_start), 0);
    tick(1'b0, 1'b0);
    check("R2 no strobe holds count", int'(line_cnt), 300);

    // Narrow timeout at 628
    go_to(628);
    check("R3 window closed at 628", int'(win_open), 0);
    tick(1'b0, 1'b0);
    check("R4 timeout 628 restarts", int'(line_cnt), 1);
    check("R10 field start on timeout", int'(field_start), 1);
    tick(1'b0, 1'b0);
    check("R10 field start single cycle", int'(field_start), 0);

    // Window edges and accepted pulse
    go_to(622);
    check("R3 window closed at 622", int'(win_open), 0);
    tick(1'b1, 1'b0);
    check("R3 window open at 623", int'(win_open), 1);
    tick(1'b0, 1'b1);
    check("R3 pulse in window restarts", int'(line_cnt), 1);
    check("R8 late pulse keeps 50 Hz", int'(is_60), 0);

    // Wide search: any pulse accepted, early count selects 60 Hz
    norm_ok = 1'b0;
    tick(1'b0, 1'b0);
    check("R5 wide window open", int'(win_open), 1);
    go_to(400);
    tick(1'b0, 1'b1);
    check("R5 wide pulse restarts", int'(field_start), 1);
    check("R8 early pulse selects 60 Hz", int'(is_60), 1);

    // Narrow window on the 60 Hz side
    norm_ok = 1'b1;
    go_to(522);
    check("R7 window closed at 522", int'(win_open), 0);
    tick(1'b0, 1'b1);
    check("R7 pulse at 522 ignored", int'(line_cnt), 522);
    tick(1'b1, 1'b0);
    check("R7 window open at 523", int'(win_open), 1);
    tick(1'b1, 1'b1);
    check("R11 pulse beats strobe", int'(line_cnt), 1);
    check("R7 60 Hz side kept", int'(is_60), 1);
    run_to_restart(peak);
    check("R4 timeout at 528", peak, 528);

    // Wide timeouts
    norm_ok = 1'b0; loop_lock = 1'b1;
    run_to_restart(peak);
    check("R6 free-mode wide timeout", peak, 628);
    force_en = 1'b1; force_60 = 1'b0;
    tick(1'b0, 1'b0);
    check("R9 forced to 50 Hz", int'(is_60), 0);
    run_to_restart(peak);
    check("R6 locked forced timeout", peak, 722);
    go_to(300);
    tick(1'b0, 1'b1);
    check("R9 accepted pulse leaves side", int'(is_60), 0);
    check("R5 forced wide pulse restarts", int'(line_cnt), 1);
    loop_lock = 1'b0;
    run_to_restart(peak);
    check("R6 unlocked forced timeout", peak, 628);
    force_60 = 1'b1;
    tick(1'b0, 1'b0);
    check("R9 forced to 60 Hz", int'(is_60), 1);
    tick(1'b0, 1'b0);
    finish_run();
  end
endmodule